// File: doc/BRIEF.md
# Hot Plug Slot Controller

This block manages one downstream slot of a switch port. It keeps a small capability register and a combined control and status register, both reached through a plain single-cycle register write port with a combinational read port. From these bits it drives the slot's active-low attention indicator and its active-low power and reference-clock enables. It also samples the active-low attention button, debounces it and records each accepted press in a sticky status bit.

A write of a non-zero indicator code starts an indicator command. The command stays busy until the neighbouring message logic acknowledges it. The acknowledge records a command-completed status. The reference clock enable follows the power enable, held back by a programmable number of millisecond ticks. A single level interrupt request summarises the pending status bits that are enabled. Building interrupt messages, sending indicator messages and loading settings at boot are left to neighbouring logic. The block only exposes the busy/acknowledge pair and the interrupt level for that logic.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, attn_led_n, pwr_en_n and refclk_en_n are 1, hp_irq and ind_cmd_busy are 0, and all three registers read 0.
- R2: Address 0x07C holds the capability bits: bit 0 button present, bit 1 power controller present, bit 3 indicator present, bit 6 hot plug capable. All other bits read 0. Address 0x1E0 holds the delay code in bits 4:3. Address 0x080 holds the control bits: 0 button interrupt enable, 4 command-done enable, 5 master interrupt enable, 7:6 indicator code, 10 power on. It also holds the status bits: 16 button pressed, 19 command done. Any other address reads 0.
- R3: With capability bit 3 clear, or an indicator code of 00 or 11, attn_led_n is 1. With code 01 it is 0. With code 10 it toggles after every BLINK_HALF_TICKS ms ticks.
- R4: A write to 0x080 whose bits 7:6 are non-zero, while capability bit 3 is set, raises ind_cmd_busy on the next cycle. Code 00, or a clear capability bit 3, starts nothing. While ind_cmd_busy is high, ind_cmd_ack lowers it and sets status bit 19.
- R5: Status bit 19 drives hp_irq only when capability bit 3 and control bits 4 and 5 are all 1.
- R6: A button press is accepted only after the synchronised attn_btn_n has stayed low for DEBOUNCE_TICKS consecutive ms ticks. Shorter pulses are ignored. An accepted press sets status bit 16 only if capability bit 0 is 1. A press held down counts once.
- R7: Status bit 16 drives hp_irq only when control bit 0, capability bit 6 and control bit 5 are all 1.
- R8: Writing 1 to status bit 16 or 19 clears it, and writing 0 leaves it. hp_irq stays high until every enabled pending status bit is cleared.
- R9: pwr_en_n is 0 exactly while capability bit 1 and control bit 10 are both 1.
- R10: refclk_en_n goes low after BASE_DELAY_TICKS << code ms ticks of continuous power-on. The codes 00, 01, 10 and 11 give 16, 32, 64 and 128 ticks by default.
- R11: refclk_en_n is never low while pwr_en_n is high. Power-off raises it at once and restarts the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| attn_btn_n | input | 1 | Attention button, low when pressed |
| attn_led_n | output | 1 | Attention indicator, low lights it |
| ind_cmd_busy | output | 1 | Indicator command waiting to be sent |
| ind_cmd_ack | input | 1 | Indicator command has been sent |
| pwr_en_n | output | 1 | Slot power enable, active low |
| refclk_en_n | output | 1 | Slot reference clock enable, active low |
| hp_irq | output | 1 | Hot plug interrupt request level |

## Verification
Some rules are checked by the assertions on every cycle. The indicator stays dark without its capability, and the interrupt never rises without the master enable. The reference clock never runs without power, and it never starts in the same edge as power. A fall of busy always leaves the command-done status set, and power never turns on without its capability. Other behaviour is shown only by the bench's scenarios against its reference model. These are the debounce length and the rejection of short glitches, the exact tick count for each delay code, the blink period, the restart of the delay after a power cycle, and the write-one-to-clear behaviour under each enable combination.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CAP = 12'h07C;
    localparam logic [ADDR_W-1:0] OFS_CTL = 12'h080;
    localparam logic [ADDR_W-1:0] OFS_DLY = 12'h1E0;

    // bit positions inside the capability word
    localparam int unsigned CAP_BTN_BIT = 0;
    localparam int unsigned CAP_PWR_BIT = 1;
    localparam int unsigned CAP_IND_BIT = 3;
    localparam int unsigned CAP_HPC_BIT = 6;

    // bit positions inside the control/status word
    localparam int unsigned CTL_BTN_IE_BIT = 0;
    localparam int unsigned CTL_CC_IE_BIT  = 4;
    localparam int unsigned CTL_HP_IE_BIT  = 5;
    localparam int unsigned CTL_IND_LO_BIT = 6;
    localparam int unsigned CTL_PWR_BIT    = 10;
    localparam int unsigned STS_BTN_BIT    = 16;
    localparam int unsigned STS_CC_BIT     = 19;

    localparam int unsigned DLY_LO_BIT = 3;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_code_e;

    typedef struct packed {
        logic hp_capable;
        logic ind_present;
        logic pwr_present;
        logic btn_present;
    } slot_caps_t;

    typedef struct packed {
        logic      pwr_ctl;
        ind_code_e ind_ctl;
        logic      hp_ie;
        logic      cc_ie;
        logic      btn_ie;
    } slot_ctl_t;

    typedef struct packed {
        logic cmd_done;
        logic btn_pressed;
    } slot_sts_t;

    function automatic slot_caps_t caps_from_word(input logic [DATA_W-1:0] w);
        slot_caps_t c;
        c.btn_present = w[CAP_BTN_BIT];
        c.pwr_present = w[CAP_PWR_BIT];
        c.ind_present = w[CAP_IND_BIT];
        c.hp_capable  = w[CAP_HPC_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] caps_to_word(input slot_caps_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CAP_BTN_BIT] = c.btn_present;
        w[CAP_PWR_BIT] = c.pwr_present;
        w[CAP_IND_BIT] = c.ind_present;
        w[CAP_HPC_BIT] = c.hp_capable;
        return w;
    endfunction

    function automatic slot_ctl_t ctl_from_word(input logic [DATA_W-1:0] w);
        slot_ctl_t c;
        c.btn_ie  = w[CTL_BTN_IE_BIT];
        c.cc_ie   = w[CTL_CC_IE_BIT];
        c.hp_ie   = w[CTL_HP_IE_BIT];
        c.ind_ctl = ind_code_e'(w[CTL_IND_LO_BIT +: 2]);
        c.pwr_ctl = w[CTL_PWR_BIT];
        return c;
    endfunction

    function automatic slot_sts_t sts_from_word(input logic [DATA_W-1:0] w);
        slot_sts_t s;
        s.btn_pressed = w[STS_BTN_BIT];
        s.cmd_done    = w[STS_CC_BIT];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_sts_to_word(input slot_ctl_t c,
                                                          input slot_sts_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_BTN_IE_BIT]      = c.btn_ie;
        w[CTL_CC_IE_BIT]       = c.cc_ie;
        w[CTL_HP_IE_BIT]       = c.hp_ie;
        w[CTL_IND_LO_BIT +: 2] = c.ind_ctl;
        w[CTL_PWR_BIT]         = c.pwr_ctl;
        w[STS_BTN_BIT]         = s.btn_pressed;
        w[STS_CC_BIT]          = s.cmd_done;
        return w;
    endfunction

    function automatic logic [1:0] dly_from_word(input logic [DATA_W-1:0] w);
        return w[DLY_LO_BIT +: 2];
    endfunction

    function automatic logic [DATA_W-1:0] dly_to_word(input logic [1:0] d);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DLY_LO_BIT +: 2] = d;
        return w;
    endfunction

    // ms ticks between power-on and clock enable for a delay code
    function automatic int unsigned delay_ticks(input logic [1:0] code,
                                                input int unsigned base);
        return base << code;
    endfunction

endpackage

// File: rtl/hp_btn_debounce.sv
module hp_btn_debounce #(
    parameter int unsigned HOLD_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_n,
    output logic press_o
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [1:0]    sync_q;
    logic          cand_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;
    logic          same;
    logic          settle;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], btn_n};
    end

    always_comb begin
        same   = (sync_q[1] == cand_q);
        settle = same && tick && (stable_q != cand_q) && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= 1'b1;
            stable_q <= 1'b1;
            cnt_q    <= '0;
        end else if (!same) begin
            cand_q <= sync_q[1];
            cnt_q  <= '0;
        end else if (tick && (stable_q != cand_q)) begin
            if (cnt_q == LAST) begin
                stable_q <= cand_q;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign press_o = settle && !cand_q;
endmodule

// File: rtl/hp_attn_indicator.sv
module hp_attn_indicator import hp_slot_pkg::*; #(
    parameter int unsigned HALF_TICKS = 500
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      present,
    input  ind_code_e code,
    output logic      led_n
);
    localparam int unsigned CW = $clog2(HALF_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] half_cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt_q <= '0;
            phase_q    <= 1'b0;
        end else if (tick) begin
            if (half_cnt_q == LAST) begin
                half_cnt_q <= '0;
                phase_q    <= ~phase_q;
            end else begin
                half_cnt_q <= half_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (!present) begin
            led_n = 1'b1;
        end else begin
            unique case (code)
                IND_ON:    led_n = 1'b0;
                IND_BLINK: led_n = phase_q;
                default:   led_n = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/hp_refclk_seq.sv
module hp_refclk_seq import hp_slot_pkg::*; #(
    parameter int unsigned BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       pwr_on,
    input  logic [1:0] dly_code,
    output logic       refclk_on
);
    localparam int unsigned MAX_TICKS = BASE_TICKS * 8;
    localparam int unsigned CW = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [CW-1:0] last;

    always_comb last = CW'(delay_ticks(dly_code, BASE_TICKS) - 1);

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (tick && !done_q) begin
            if (cnt_q >= last) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign refclk_on = pwr_on && done_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl import hp_slot_pkg::*; #(
    parameter int unsigned DEBOUNCE_TICKS   = 10,
    parameter int unsigned BLINK_HALF_TICKS = 500,
    parameter int unsigned BASE_DELAY_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              attn_btn_n,
    output logic              attn_led_n,
    output logic              ind_cmd_busy,
    input  logic              ind_cmd_ack,
    output logic              pwr_en_n,
    output logic              refclk_en_n,
    output logic              hp_irq
);
    slot_caps_t caps_q;
    slot_ctl_t  ctl_q;
    slot_sts_t  sts_q;
    logic [1:0] dly_q;
    logic       busy_q;

    logic       wr_cap, wr_ctl, wr_dly;
    slot_ctl_t  ctl_wr;
    slot_sts_t  sts_clr;
    slot_sts_t  sts_set;
    logic       cmd_start, cmd_done;
    logic       btn_press;
    logic       pwr_on, refclk_on;

    always_comb begin
        wr_cap    = reg_wr && (reg_addr == OFS_CAP);
        wr_ctl    = reg_wr && (reg_addr == OFS_CTL);
        wr_dly    = reg_wr && (reg_addr == OFS_DLY);
        ctl_wr    = ctl_from_word(reg_wdata);
        sts_clr   = wr_ctl ? sts_from_word(reg_wdata) : '0;
        cmd_start = wr_ctl && (ctl_wr.ind_ctl != IND_RSVD) && caps_q.ind_present;
        cmd_done  = ind_cmd_ack && busy_q && !cmd_start;
        sts_set.btn_pressed = btn_press && caps_q.btn_present;
        sts_set.cmd_done    = cmd_done;
        pwr_on    = caps_q.pwr_present && ctl_q.pwr_ctl;
    end

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            caps_q <= '0;
            ctl_q  <= '0;
            dly_q  <= '0;
        end else begin
            if (wr_cap) caps_q <= caps_from_word(reg_wdata);
            if (wr_ctl) ctl_q  <= ctl_wr;
            if (wr_dly) dly_q  <= dly_from_word(reg_wdata);
        end
    end

    // sticky status, event set wins over write-one clear
    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    // indicator command handshake
    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (cmd_start) busy_q <= 1'b1;
        else if (cmd_done)  busy_q <= 1'b0;
    end

    hp_btn_debounce #(.HOLD_TICKS(DEBOUNCE_TICKS)) u_debounce (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .btn_n   (attn_btn_n),
        .press_o (btn_press)
    );

    hp_attn_indicator #(.HALF_TICKS(BLINK_HALF_TICKS)) u_indicator (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .present (caps_q.ind_present),
        .code    (ctl_q.ind_ctl),
        .led_n   (attn_led_n)
    );

    hp_refclk_seq #(.BASE_TICKS(BASE_DELAY_TICKS)) u_refclk (
        .clk       (clk),
        .rst       (rst),
        .tick      (ms_tick),
        .pwr_on    (pwr_on),
        .dly_code  (dly_q),
        .refclk_on (refclk_on)
    );

    always_comb begin
        hp_irq = ctl_q.hp_ie &&
                 ((sts_q.btn_pressed && ctl_q.btn_ie && caps_q.hp_capable) ||
                  (sts_q.cmd_done && ctl_q.cc_ie && caps_q.ind_present));
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CAP: reg_rdata = caps_to_word(caps_q);
            OFS_CTL: reg_rdata = ctl_sts_to_word(ctl_q, sts_q);
            OFS_DLY: reg_rdata = dly_to_word(dly_q);
            default: reg_rdata = '0;
        endcase
    end

    assign ind_cmd_busy = busy_q;
    assign pwr_en_n     = ~pwr_on;
    assign refclk_en_n  = ~refclk_on;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic attn_led_n,
    input logic pwr_en_n,
    input logic refclk_en_n,
    input logic hp_irq,
    input logic ind_cmd_busy,
    input logic cap_ind,
    input logic cap_pwr,
    input logic hp_ie,
    input logic cc_sts
);
    AST_LED_DARK_NO_IND: assert property (@(posedge clk) disable iff (rst)
        !cap_ind |-> attn_led_n);                                    // R3

    AST_BUSY_DROP_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(ind_cmd_busy) |-> cc_sts);                             // R4

    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
        hp_irq |-> hp_ie);                                           // R5

    AST_PWR_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst)
        !pwr_en_n |-> cap_pwr);                                      // R9

    AST_REFCLK_AFTER_PWR: assert property (@(posedge clk) disable iff (rst)
        $fell(refclk_en_n) |-> $past(!pwr_en_n));                    // R10

    AST_REFCLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        !refclk_en_n |-> !pwr_en_n);                                 // R11
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .attn_led_n   (attn_led_n),
    .pwr_en_n     (pwr_en_n),
    .refclk_en_n  (refclk_en_n),
    .hp_irq       (hp_irq),
    .ind_cmd_busy (ind_cmd_busy),
    .cap_ind      (caps_q.ind_present),
    .cap_pwr      (caps_q.pwr_present),
    .hp_ie        (ctl_q.hp_ie),
    .cc_sts       (sts_q.cmd_done)
);

// File: tb/hp_slot_ctrl_tb_top.sv
module hp_slot_ctrl_tb_top;
    // 20-unit period: 50 MHz with 1 ns units
    localparam int DEB   = 10;
    localparam int HALF  = 4;
    localparam int BASE  = 16;
    localparam int TICKP = 5;   // clocks per ms tick

    logic        clk = 0;
    logic        rst = 1;
    logic        ms_tick = 0;
    logic        reg_wr = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        attn_btn_n = 1;
    logic        attn_led_n;
    logic        ind_cmd_busy;
    logic        ind_cmd_ack = 0;
    logic        pwr_en_n;
    logic        refclk_en_n;
    logic        hp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    hp_slot_ctrl #(.DEBOUNCE_TICKS(DEB), .BLINK_HALF_TICKS(HALF),
                   .BASE_DELAY_TICKS(BASE)) dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .attn_btn_n(attn_btn_n), .attn_led_n(attn_led_n),
        .ind_cmd_busy(ind_cmd_busy), .ind_cmd_ack(ind_cmd_ack),
        .pwr_en_n(pwr_en_n), .refclk_en_n(refclk_en_n), .hp_irq(hp_irq));

    initial forever #10 clk = ~clk;

    initial forever begin
        repeat (TICKP - 1) @(negedge clk);
        ms_tick = 1;
        @(negedge clk);
        ms_tick = 0;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_s1, m_s2, m_cand, m_stable, m_dcnt;
    int m_bcnt, m_phase, m_rcnt, m_rdone;
    int m_cbtn, m_cpwr, m_cind, m_chp;
    int m_abpe, m_ccie, m_hpie, m_aic, m_pcc;
    int m_abp, m_cc, m_busy, m_dly;

    task automatic model_step();
        int press, pon, start, ccset, wr80;
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_cand = 1; m_stable = 1; m_dcnt = 0;
            m_bcnt = 0; m_phase = 0; m_rcnt = 0; m_rdone = 0;
            m_cbtn = 0; m_cpwr = 0; m_cind = 0; m_chp = 0;
            m_abpe = 0; m_ccie = 0; m_hpie = 0; m_aic = 0; m_pcc = 0;
            m_abp = 0; m_cc = 0; m_busy = 0; m_dly = 0;
            return;
        end
        press = 0;
        if (m_s2 != m_cand) begin
            m_cand = m_s2; m_dcnt = 0;
        end else if (ms_tick && m_stable != m_cand) begin
            if (m_dcnt == DEB - 1) begin
                m_stable = m_cand; m_dcnt = 0; press = (m_cand == 0);
            end else m_dcnt++;
        end
        m_s2 = m_s1; m_s1 = attn_btn_n;
        if (ms_tick) begin
            if (m_bcnt == HALF - 1) begin m_bcnt = 0; m_phase ^= 1; end
            else m_bcnt++;
        end
        pon = m_cpwr && m_pcc;
        if (!pon) begin m_rcnt = 0; m_rdone = 0; end
        else if (ms_tick && !m_rdone) begin
            if (m_rcnt >= (BASE << m_dly) - 1) m_rdone = 1;
            else m_rcnt++;
        end
        wr80  = reg_wr && reg_addr == 12'h080;
        start = wr80 && reg_wdata[7:6] != 0 && m_cind;
        ccset = 0;
        if (start) m_busy = 1;
        else if (ind_cmd_ack && m_busy) begin m_busy = 0; ccset = 1; end
        if (wr80 && reg_wdata[16]) m_abp = 0;
        if (press && m_cbtn) m_abp = 1;
        if (wr80 && reg_wdata[19]) m_cc = 0;
        if (ccset) m_cc = 1;
        if (reg_wr && reg_addr == 12'h07C) begin
            m_cbtn = reg_wdata[0]; m_cpwr = reg_wdata[1];
            m_cind = reg_wdata[3]; m_chp = reg_wdata[6];
        end
        if (wr80) begin
            m_abpe = reg_wdata[0]; m_ccie = reg_wdata[4]; m_hpie = reg_wdata[5];
            m_aic = reg_wdata[7:6]; m_pcc = reg_wdata[10];
        end
        if (reg_wr && reg_addr == 12'h1E0) m_dly = reg_wdata[4:3];
    endtask

    task automatic model_compare();
        logic [31:0] er;
        logic led, irq, pwrn, rckn;
        led  = (!m_cind) ? 1'b1 : (m_aic == 1) ? 1'b0 : (m_aic == 2) ? m_phase[0] : 1'b1;
        irq  = m_hpie && ((m_abp && m_abpe && m_chp) || (m_cc && m_ccie && m_cind));
        pwrn = !(m_cpwr && m_pcc);
        rckn = !(m_cpwr && m_pcc && m_rdone);
        er = 0;
        case (reg_addr)
            12'h07C: er = {25'b0, m_chp[0], 2'b0, m_cind[0], 1'b0, m_cpwr[0], m_cbtn[0]};
            12'h080: er = {12'b0, m_cc[0], 2'b0, m_abp[0], 5'b0, m_pcc[0], 2'b0,
                           m_aic[1:0], m_hpie[0], m_ccie[0], 3'b0, m_abpe[0]};
            12'h1E0: er = {27'b0, m_dly[1:0], 3'b0};
            default: er = 0;
        endcase
        check("R3 led model", {31'b0, attn_led_n}, {31'b0, led});
        check("R4 busy model", {31'b0, ind_cmd_busy}, {31'b0, m_busy[0]});
        check("R5 R7 irq model", {31'b0, hp_irq}, {31'b0, irq});
        check("R9 pwr model", {31'b0, pwr_en_n}, {31'b0, pwrn});
        check("R10 R11 refclk model", {31'b0, refclk_en_n}, {31'b0, rckn});
        check("R2 rdata model", reg_rdata, er);
    endtask

    always @(posedge clk) begin
        model_step();
        #5;
        if (!done) model_compare();
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ack();
        @(negedge clk); ind_cmd_ack = 1;
        @(negedge clk); ind_cmd_ack = 0;
    endtask

    task automatic wait_ms(input int n);
        repeat (n * TICKP) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int toggles;
        logic prev;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check("R1 led", {31'b0, attn_led_n}, 1);
        check("R1 pwr", {31'b0, pwr_en_n}, 1);
        check("R1 refclk", {31'b0, refclk_en_n}, 1);
        check("R1 irq", {31'b0, hp_irq}, 0);
        check("R1 busy", {31'b0, ind_cmd_busy}, 0);
        rd(12'h080, v); check("R1 ctl", v, 0);
        rd(12'h07C, v); check("R1 cap", v, 0);
        rd(12'h1E0, v); check("R1 dly", v, 0);

        // R2 register map
        wr(12'h07C, 32'hFFFF_FFFF); rd(12'h07C, v); check("R2 cap bits", v, 32'h4B);
        wr(12'h1E0, 32'hFFFF_FFFF); rd(12'h1E0, v); check("R2 dly bits", v, 32'h18);
        rd(12'h084, v); check("R2 unmapped", v, 0);
        wr(12'h1E0, 0);

        // R4 reserved code, then a real command
        wr(12'h080, 0);
        check("R4 reserved no cmd", {31'b0, ind_cmd_busy}, 0);
        wr(12'h080, 32'h40);
        check("R4 cmd busy", {31'b0, ind_cmd_busy}, 1);
        check("R3 led on", {31'b0, attn_led_n}, 0);
        ack();
        check("R4 busy cleared", {31'b0, ind_cmd_busy}, 0);
        rd(12'h080, v); check("R4 done status", v, 32'h0008_0040);

        // R5 gating
        wr(12'h080, 32'h30);
        check("R5 irq on", {31'b0, hp_irq}, 1);
        check("R3 led off code00", {31'b0, attn_led_n}, 1);
        wr(12'h080, 32'h20);
        check("R5 cc_ie off", {31'b0, hp_irq}, 0);
        wr(12'h080, 32'h10);
        check("R5 hp_ie off", {31'b0, hp_irq}, 0);
        wr(12'h080, 32'h30 | 32'h0001_0000);
        check("R8 zero write keeps", {31'b0, hp_irq}, 1);
        wr(12'h080, 32'h30 | 32'h0008_0000);
        check("R8 clear irq", {31'b0, hp_irq}, 0);
        rd(12'h080, v); check("R8 cc cleared", v, 32'h30);

        // R3 blink
        wr(12'h080, 32'h80); ack();
        prev = attn_led_n; toggles = 0;
        for (int i = 0; i < 40 * TICKP; i++) begin
            @(negedge clk);
            if (attn_led_n !== prev) toggles++;
            prev = attn_led_n;
        end
        check("R3 blink toggles", (toggles >= 9 && toggles <= 11), 1);
        wr(12'h080, 32'hC0); ack();
        check("R3 code11 dark", {31'b0, attn_led_n}, 1);
        wr(12'h080, 32'h0008_0040); ack();
        wr(12'h07C, 32'h43);
        check("R3 no ind dark", {31'b0, attn_led_n}, 1);
        wr(12'h080, 32'h0008_0040);
        check("R4 no ind no cmd", {31'b0, ind_cmd_busy}, 0);

        // R6 R7 button
        wr(12'h07C, 32'h4B);
        wr(12'h080, 32'h21);
        attn_btn_n = 0; wait_ms(4); attn_btn_n = 1; wait_ms(15);
        rd(12'h080, v); check("R6 glitch ignored", {31'b0, v[16]}, 0);
        attn_btn_n = 0; wait_ms(14);
        rd(12'h080, v); check("R6 press latched", {31'b0, v[16]}, 1);
        check("R7 irq on press", {31'b0, hp_irq}, 1);
        wr(12'h080, 32'h01);
        check("R7 hp_ie off", {31'b0, hp_irq}, 0);
        wr(12'h07C, 32'h0B); wr(12'h080, 32'h21);
        check("R7 not capable", {31'b0, hp_irq}, 0);
        wr(12'h07C, 32'h4B);
        check("R7 irq back", {31'b0, hp_irq}, 1);
        wr(12'h080, 32'h0001_0021);
        check("R8 btn clear irq", {31'b0, hp_irq}, 0);
        wait_ms(15);
        rd(12'h080, v); check("R6 held counts once", {31'b0, v[16]}, 0);
        attn_btn_n = 1; wait_ms(15);
        wr(12'h07C, 32'h4A);
        attn_btn_n = 0; wait_ms(14);
        rd(12'h080, v); check("R6 no btn cap", {31'b0, v[16]}, 0);
        attn_btn_n = 1; wait_ms(15);
        wr(12'h07C, 32'h4B);

        // R9 R10 R11 power and refclk
        wr(12'h1E0, 32'h08);
        wr(12'h080, 32'h400);
        check("R9 pwr on", {31'b0, pwr_en_n}, 0);
        wait_ms(28);
        check("R10 code01 early", {31'b0, refclk_en_n}, 1);
        wait_ms(8);
        check("R10 code01 on", {31'b0, refclk_en_n}, 0);
        wr(12'h080, 0);
        check("R11 off at once", {31'b0, refclk_en_n}, 1);
        wr(12'h080, 32'h400);
        wait_ms(28);
        check("R11 count restarted", {31'b0, refclk_en_n}, 1);
        wr(12'h080, 0);
        wr(12'h1E0, 32'h18);
        wr(12'h080, 32'h400);
        wait_ms(120);
        check("R10 code11 early", {31'b0, refclk_en_n}, 1);
        wait_ms(12);
        check("R10 code11 on", {31'b0, refclk_en_n}, 0);
        wr(12'h080, 0);
        wr(12'h1E0, 0);
        wr(12'h080, 32'h400);
        wait_ms(12);
        check("R10 code00 early", {31'b0, refclk_en_n}, 1);
        wait_ms(8);
        check("R10 code00 on", {31'b0, refclk_en_n}, 0);
        wr(12'h07C, 32'h49);
        check("R9 no pwr cap", {31'b0, pwr_en_n}, 1);
        check("R11 refclk follows", {31'b0, refclk_en_n}, 1);

        wait_ms(2);
        finish_run();
    end
endmodule